// File: doc/BRIEF.md
# LED Open/Short Fault Diagnostic Sampler

This block diagnoses faults on the outputs of a 24-channel constant-current LED driver. It runs from the grayscale clock and counts its rising edges to track where it is inside each PWM period. At two points in every period it stores the per-channel comparator results. The early point is edge 9, while a channel that is lit is still driving. The late point is the second-to-last edge of the period, after the channels have gone dark and the internal pull-up has charged the idle pins. Each point is stored in a bank of its own.

The pairing of the two banks tells the failure modes apart. A healthy channel reads high at the late point only. An open LED also reads low at the early point. A shorted LED reads high at both points. An output shorted to ground reads low at both points. A per-channel 3-bit fault code is decoded from the banks. A one-cycle strobe marks the cycle in which a full period's codes are ready. Channels whose grayscale setting defeats the measurement (dark before edge 9, or still lit at the late point) are masked by the caller and report "ok".

Top module: `led_fault_sampler`

## Requirements
- R1: Bank 1 (`bank1_low`, `bank1_short`) loads `cmp_low` and `cmp_short` on the 9th rising edge of `gclk` of each PWM period and holds them otherwise. The first edge after reset release is edge 1.
- R2: Bank 2 (`bank2_low`, `bank2_short`) loads the comparators on edge N of each period. The period is 256, 1024 or 4096 edges and N is the period length minus one. `gs_mode` encodes 2'b00 = 8-bit (N=255), 2'b01 = 10-bit (N=1023), and 2'b10 or 2'b11 = 12-bit (N=4095).
- R3: `fault_code[3c+2:3c]` for channel c is decoded from the tuple (bank1_low, bank1_short, bank2_low, bank2_short) of that channel. 0001 gives 0 (ok), 1001 gives 1 (open), 0101 gives 2 (shorted LED), 1010 gives 3 (short to ground), and any other tuple gives 4 (indeterminate).
- R4: While `ign_mask[c]` is 1, channel c's code is 0 whatever its banks hold. The mask acts combinationally on the code and does not touch the banks.
- R5: While `rst_n` is low (asynchronous), all four banks are 0 and `codes_valid` is 0. With the mask clear, every code then reads 4.
- R6: `gs_mode` is taken only on the first edge of a period. A change made partway through a period leaves that period's length and N unchanged and applies from the next period.
- R7: `codes_valid` is high for exactly the one cycle that follows the edge-N capture, and is low in every other cycle.
- R8: Between its own capture edges, each bank holds its value, so both banks are unchanged on the edge after edge N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Grayscale clock; every rising edge advances the period position |
| rst_n | input | 1 | Asynchronous active-low reset |
| gs_mode | input | 2 | Counter resolution, sampled at period start |
| cmp_low | input | 24 | Per-channel low-output comparator results |
| cmp_short | input | 24 | Per-channel short-detect comparator results |
| ign_mask | input | 24 | Per-channel mask forcing the fault code to 0 |
| bank1_low | output | 24 | Low-output bits captured at edge 9 |
| bank1_short | output | 24 | Short-detect bits captured at edge 9 |
| bank2_low | output | 24 | Low-output bits captured at edge N |
| bank2_short | output | 24 | Short-detect bits captured at edge N |
| fault_code | output | 72 | 3-bit fault code per channel, channel c at bits 3c+2:3c |
| codes_valid | output | 1 | One-cycle strobe after the edge-N capture |

## Verification
On every cycle the assertions check the following. The reset state is cleared. The valid strobe lasts one cycle and the next one comes at least 255 cycles later. Both banks stay still on the edge after a strobe. Every masked channel reads 0, and no code is ever above 4. Only the bench scenarios can show that the captures land on exactly edge 9 and edge N and not on a neighbouring edge. The bench drives different comparator values on the edges around each capture point to make this visible. The bench scenarios also cover the decode of each fault tuple, the period lengths of all three modes, and the deferral of a mode change to the next period.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;

  typedef enum logic [1:0] {
    GS_RES_8   = 2'b00,
    GS_RES_10  = 2'b01,
    GS_RES_12  = 2'b10,
    GS_RES_12B = 2'b11
  } gs_res_e;

  typedef enum logic [2:0] {
    FLT_OK    = 3'd0,
    FLT_OPEN  = 3'd1,
    FLT_SHORT = 3'd2,
    FLT_GND   = 3'd3,
    FLT_UNK   = 3'd4
  } flt_code_e;

  // Early/late snapshot of one channel
  typedef struct packed {
    logic lo_early;
    logic hi_early;
    logic lo_late;
    logic hi_late;
  } snap_t;

  function automatic flt_code_e decode_snap(input snap_t s);
    flt_code_e r;
    case ({s.lo_early, s.hi_early, s.lo_late, s.hi_late})
      4'b0001: r = FLT_OK;
      4'b1001: r = FLT_OPEN;
      4'b0101: r = FLT_SHORT;
      4'b1010: r = FLT_GND;
      default: r = FLT_UNK;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gs_edge_tracker.sv
module gs_edge_tracker #(
  parameter int CW         = 13,
  parameter int EARLY_EDGE = 9,
  parameter int RES_LO     = 8,
  parameter int RES_MID    = 10,
  parameter int RES_HI     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  output logic       cap_early,
  output logic       cap_late
);
  import led_fault_pkg::*;

  localparam logic [CW-1:0] LEN_LO  = CW'(1) << RES_LO;
  localparam logic [CW-1:0] LEN_MID = CW'(1) << RES_MID;
  localparam logic [CW-1:0] LEN_HI  = CW'(1) << RES_HI;
  localparam logic [CW-1:0] EARLY_V = CW'(EARLY_EDGE);

  logic [CW-1:0] edge_q, edge_d;
  logic [1:0]    mode_q, mode_d;
  logic          mode_en;
  logic [CW-1:0] len_cur;
  logic          period_start;

  always_comb begin
    case (gs_res_e'(mode_q))
      GS_RES_8:  len_cur = LEN_LO;
      GS_RES_10: len_cur = LEN_MID;
      default:   len_cur = LEN_HI;
    endcase
  end

  always_comb begin
    period_start = (edge_q == '0) || (edge_q == len_cur);
    edge_d       = period_start ? CW'(1) : edge_q + CW'(1);
    mode_en      = period_start;
    mode_d       = mode_in;
    cap_early    = (edge_d == EARLY_V);
    cap_late     = (edge_d == len_cur - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
    end else begin
      edge_q <= edge_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= GS_RES_12;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/diag_bank.sv
module diag_bank #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_low,
  input  logic [W-1:0] d_short,
  output logic [W-1:0] q_low,
  output logic [W-1:0] q_short
);

  logic [W-1:0] low_d, short_d;

  always_comb begin
    low_d   = d_low;
    short_d = d_short;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_low   <= '0;
      q_short <= '0;
    end else if (load) begin
      q_low   <= low_d;
      q_short <= short_d;
    end
  end

endmodule

// File: rtl/fault_classifier.sv
module fault_classifier #(
  parameter int NCH = 24,
  parameter int CDW = 3
) (
  input  logic [NCH-1:0]     lo_early,
  input  logic [NCH-1:0]     hi_early,
  input  logic [NCH-1:0]     lo_late,
  input  logic [NCH-1:0]     hi_late,
  input  logic [NCH-1:0]     skip,
  output logic [CDW*NCH-1:0] codes
);
  import led_fault_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    snap_t     s;
    flt_code_e k;
    always_comb begin
      s.lo_early = lo_early[c];
      s.hi_early = hi_early[c];
      s.lo_late  = lo_late[c];
      s.hi_late  = hi_late[c];
      k          = decode_snap(s);
      codes[c*CDW +: CDW] = skip[c] ? CDW'(FLT_OK) : CDW'(k);
    end
  end

endmodule

// File: rtl/led_fault_sampler.sv
module led_fault_sampler #(
  parameter int NCH        = 24,
  parameter int EARLY_EDGE = 9,
  parameter int RES_LO     = 8,
  parameter int RES_MID    = 10,
  parameter int RES_HI     = 12
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic [1:0]       gs_mode,
  input  logic [NCH-1:0]   cmp_low,
  input  logic [NCH-1:0]   cmp_short,
  input  logic [NCH-1:0]   ign_mask,
  output logic [NCH-1:0]   bank1_low,
  output logic [NCH-1:0]   bank1_short,
  output logic [NCH-1:0]   bank2_low,
  output logic [NCH-1:0]   bank2_short,
  output logic [3*NCH-1:0] fault_code,
  output logic             codes_valid
);

  localparam int CW  = RES_HI + 1;
  localparam int CDW = 3;

  logic cap_early, cap_late;
  logic valid_d, valid_q;

  gs_edge_tracker #(
    .CW(CW), .EARLY_EDGE(EARLY_EDGE),
    .RES_LO(RES_LO), .RES_MID(RES_MID), .RES_HI(RES_HI)
  ) u_trk (
    .clk      (gclk),
    .rst_n    (rst_n),
    .mode_in  (gs_mode),
    .cap_early(cap_early),
    .cap_late (cap_late)
  );

  diag_bank #(.W(NCH)) u_bank_early (
    .clk    (gclk),
    .rst_n  (rst_n),
    .load   (cap_early),
    .d_low  (cmp_low),
    .d_short(cmp_short),
    .q_low  (bank1_low),
    .q_short(bank1_short)
  );

  diag_bank #(.W(NCH)) u_bank_late (
    .clk    (gclk),
    .rst_n  (rst_n),
    .load   (cap_late),
    .d_low  (cmp_low),
    .d_short(cmp_short),
    .q_low  (bank2_low),
    .q_short(bank2_short)
  );

  fault_classifier #(.NCH(NCH), .CDW(CDW)) u_cls (
    .lo_early(bank1_low),
    .hi_early(bank1_short),
    .lo_late (bank2_low),
    .hi_late (bank2_short),
    .skip    (ign_mask),
    .codes   (fault_code)
  );

  always_comb valid_d = cap_late;

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign codes_valid = valid_q;

endmodule

// File: rtl/led_fault_sampler_chk.sv
module led_fault_sampler_chk #(
  parameter int NCH = 24
) (
  input logic             gclk,
  input logic             rst_n,
  input logic [NCH-1:0]   ign_mask,
  input logic [NCH-1:0]   bank1_low,
  input logic [NCH-1:0]   bank1_short,
  input logic [NCH-1:0]   bank2_low,
  input logic [NCH-1:0]   bank2_short,
  input logic [3*NCH-1:0] fault_code,
  input logic             codes_valid
);

  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (codes_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hFF) begin
      gap_q  <= gap_q + 8'd1;
    end
  end

  // R5
  reset_clear_chk: assert property (@(posedge gclk)
    !rst_n |-> (bank1_low == '0 && bank1_short == '0 &&
                bank2_low == '0 && bank2_short == '0 && !codes_valid));

  // R7
  valid_pulse_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    codes_valid |=> !codes_valid);

  // R7
  valid_gap_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    (codes_valid && seen_q) |-> (gap_q == 8'hFF));

  // R8
  banks_hold_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    codes_valid |=> ($stable(bank1_low) && $stable(bank1_short) &&
                     $stable(bank2_low) && $stable(bank2_short)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R4
    mask_zero_chk: assert property (@(posedge gclk) disable iff (!rst_n)
      ign_mask[c] |-> (fault_code[3*c +: 3] == 3'd0));
    // R3
    code_range_chk: assert property (@(posedge gclk) disable iff (!rst_n)
      fault_code[3*c +: 3] <= 3'd4);
  end

endmodule

bind led_fault_sampler led_fault_sampler_chk #(.NCH(NCH)) u_chk (
  .gclk       (gclk),
  .rst_n      (rst_n),
  .ign_mask   (ign_mask),
  .bank1_low  (bank1_low),
  .bank1_short(bank1_short),
  .bank2_low  (bank2_low),
  .bank2_short(bank2_short),
  .fault_code (fault_code),
  .codes_valid(codes_valid)
);

// File: tb/sim_led_fault_sampler.sv
`timescale 1ns/1ps
module sim_led_fault_sampler;

  localparam int NCH  = 24;
  localparam int NROW = 8;
  // {lo1, sh1, lo2, sh2, ign, code[2:0]}
  localparam logic [7:0] VEC [NROW] = '{
    8'b0001_0_000, 8'b1001_0_001, 8'b0101_0_010, 8'b1010_0_011,
    8'b0000_0_100, 8'b0110_0_100, 8'b0000_1_000, 8'b0101_1_000
  };

  logic             gclk;
  logic             rst_n;
  logic [1:0]       gs_mode;
  logic [NCH-1:0]   cmp_low, cmp_short, ign_mask;
  logic [NCH-1:0]   bank1_low, bank1_short, bank2_low, bank2_short;
  logic [3*NCH-1:0] fault_code;
  logic             codes_valid;

  int n_run, n_fail;
  int pos, plen;

  logic [NCH-1:0]   p1_low, p1_sh, p2_low, p2_sh, msk;
  logic [3*NCH-1:0] exp_codes;

  led_fault_sampler u0 (
    .gclk(gclk), .rst_n(rst_n), .gs_mode(gs_mode),
    .cmp_low(cmp_low), .cmp_short(cmp_short), .ign_mask(ign_mask),
    .bank1_low(bank1_low), .bank1_short(bank1_short),
    .bank2_low(bank2_low), .bank2_short(bank2_short),
    .fault_code(fault_code), .codes_valid(codes_valid)
  );

  initial gclk = 1'b0;
  always #4 gclk = ~gclk;

  function automatic int len_of(input logic [1:0] m);
    return (m == 2'b00) ? 256 : (m == 2'b01) ? 1024 : 4096;
  endfunction

  // period position from the requirements: first edge after reset is 1
  always @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= 0;
      plen <= 4096;
    end else if (pos == 0 || pos == plen) begin
      pos  <= 1;
      plen <= len_of(gs_mode);
    end else begin
      pos  <= pos + 1;
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int t);
    forever begin
      @(negedge gclk);
      if (pos == t) break;
    end
  endtask

  task automatic run_period();
    wait_pos(8);
    cmp_low = p1_low; cmp_short = p1_sh; ign_mask = msk;
    wait_pos(9);
    chk(bank1_low == p1_low && bank1_short == p1_sh, "R1 bank1 at edge 9",
        {bank1_low, bank1_short}, {p1_low, p1_sh});
    cmp_low = ~p1_low; cmp_short = ~p1_sh;
    wait_pos(plen - 2);
    cmp_low = p2_low; cmp_short = p2_sh;
    wait_pos(plen - 1);
    chk(bank2_low == p2_low && bank2_short == p2_sh, "R2 bank2 at edge N",
        {bank2_low, bank2_short}, {p2_low, p2_sh});
    chk(codes_valid == 1'b1, "R7 strobe after edge N", codes_valid, 1);
    chk(bank1_low == p1_low && bank1_short == p1_sh, "R8 bank1 held",
        {bank1_low, bank1_short}, {p1_low, p1_sh});
    chk(fault_code == exp_codes, "R3 R4 fault codes", fault_code, exp_codes);
    cmp_low = ~p2_low; cmp_short = ~p2_sh;
    wait_pos(plen);
    chk(codes_valid == 1'b0, "R7 strobe one cycle", codes_valid, 0);
    chk(bank2_low == p2_low && bank2_short == p2_sh, "R8 bank2 held",
        {bank2_low, bank2_short}, {p2_low, p2_sh});
  endtask

  initial begin
    #1200000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b1; gs_mode = 2'b00;
    cmp_low = '0; cmp_short = '0; ign_mask = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge gclk);
    // R5 reset state
    chk(bank1_low == '0 && bank1_short == '0 && bank2_low == '0 && bank2_short == '0,
        "R5 banks clear", {bank1_low, bank1_short, bank2_low, bank2_short}, 0);
    chk(codes_valid == 1'b0, "R5 valid low", codes_valid, 0);
    begin
      logic [3*NCH-1:0] all4;
      for (int c = 0; c < NCH; c++) all4[3*c +: 3] = 3'd4;
      chk(fault_code == all4, "R5 codes indeterminate", fault_code, all4);
    end
    rst_n = 1'b1;

    // first period after reset: mode latched on edge 1 (8-bit)
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [7:0] v;
        v = VEC[(c + p) % NROW];
        p1_low[c] = v[7]; p1_sh[c] = v[6];
        p2_low[c] = v[5]; p2_sh[c] = v[4];
        msk[c]    = v[3];
        exp_codes[3*c +: 3] = v[2:0];
      end
      run_period();
    end

    // R6: mode change partway through an 8-bit period
    wait_pos(100);
    gs_mode = 2'b01;
    wait_pos(254);
    chk(codes_valid == 1'b0, "R6 no early strobe", codes_valid, 0);
    wait_pos(255);
    chk(codes_valid == 1'b1, "R6 old length kept", codes_valid, 1);
    wait_pos(255);
    chk(codes_valid == 1'b0, "R6 new length applies", codes_valid, 0);
    wait_pos(1023);
    chk(codes_valid == 1'b1, "R2 10-bit edge 1023", codes_valid, 1);
    gs_mode = 2'b10;

    // 12-bit period: every channel open, channel 0 masked
    p1_low = '1; p1_sh = '0; p2_low = '0; p2_sh = '1;
    msk = '0; msk[0] = 1'b1;
    for (int c = 0; c < NCH; c++) exp_codes[3*c +: 3] = (c == 0) ? 3'd0 : 3'd1;
    run_period();
    chk(plen == 4096, "R2 12-bit period", plen, 4096);

    // R4: mask is combinational and leaves the banks alone
    ign_mask = '1;
    #1;
    chk(fault_code == '0, "R4 mask all", fault_code, 0);
    ign_mask = '0;
    #1;
    begin
      logic [3*NCH-1:0] allopen;
      for (int c = 0; c < NCH; c++) allopen[3*c +: 3] = 3'd1;
      chk(fault_code == allopen, "R4 banks untouched", fault_code, allopen);
    end

    // R5: asynchronous reset mid-run
    @(negedge gclk);
    rst_n = 1'b0;
    #1;
    chk(bank1_low == '0 && bank1_short == '0 && bank2_low == '0 && bank2_short == '0,
        "R5 async clear", {bank1_low, bank1_short, bank2_low, bank2_short}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule